// File: doc/BRIEF.md
# Lane-Partitioned Saturating Packed Adder

This block adds or subtracts two 64-bit words treated as packed vectors of small integers. One adder datapath spans the whole word, and its carry chain is cut at lane boundaries picked by a control input on each operation. The word can hold eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Each lane is computed on its own, as signed or unsigned, and either wraps modulo its width or clamps to the nearest end of its range when the true result does not fit.

Subtraction inverts the second operand and feeds a carry of one into the lowest bit of every lane. For each byte position the block reports whether the lane holding that byte overflowed. Results and flags are registered, one cycle after the valid strobe. Media and signal-processing pipelines use it for pixel and audio-sample arithmetic where clipping is wanted.

Top module: `simd_sat_add`

## Requirements
- R1: `laneSel` picks the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 or 3 give two 32-bit lanes. Lane k covers the bits from k times the lane width upward. No carry or borrow crosses from one lane into the next in any mode.
- R2: With `satEn` low, each lane of `result` is the lane sum or difference modulo 2 to the power of the lane width.
- R3: With `subEn` high, each lane computes opA lane minus opB lane, by adding the inverted opB lane with a carry-in of one.
- R4: Signed addition (`signedEn` high) overflows in a lane only when both operand lanes have the same sign and the lane result has the other sign.
- R5: Signed subtraction overflows in a lane only when the operand lanes differ in sign and the result sign differs from the opA lane sign.
- R6: Unsigned addition overflows on a carry out of the lane's top bit. Unsigned subtraction overflows when it needs a borrow, that is, when opB lane is greater than opA lane.
- R7: With `satEn` high, a signed lane that overflows upward gives the largest positive value (0 then all ones). One that overflows downward gives the most negative value (1 then all zeros).
- R8: With `satEn` high, an unsigned lane that overflows on addition gives all ones, and one that underflows on subtraction gives zero.
- R9: `ovfFlags` bit i belongs to byte i of the word. It is set when the lane holding byte i overflowed under R4 to R6, in both wrap and saturating mode. A 16-bit or 32-bit lane's flag therefore appears on every byte the lane covers.
- R10: `outValid` is `inValid` delayed by one clock. `result` and `ovfFlags` load only on a cycle with `inValid` high, and they hold their values otherwise.
- R11: While `rstN` is low, `outValid`, `result` and `ovfFlags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| laneSel | input | 2 | Lane width code (0: 8, 1: 16, 2 or 3: 32 bits) |
| satEn | input | 1 | 1 = clamp on overflow, 0 = wrap |
| signedEn | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| subEn | input | 1 | 1 = opA minus opB, 0 = opA plus opB |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| outValid | output | 1 | Result registers were loaded on the previous edge |
| result | output | 64 | Packed lane results |
| ovfFlags | output | 8 | Per-byte overflow flag of the lane holding that byte |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and eight bytes per word. All three lane widths are reachable with these values. Lanes of 32 bits still fit, with their sign, into the 64-bit integers the reference model uses. Directed cases place carries and borrows exactly at the 8-, 16- and 32-bit seams and hit each clamp end in every signedness and direction. Random words then cover all eight control combinations in every lane-width code, including code 3.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    LANE8  = 2'd0,
    LANE16 = 2'd1,
    LANE32 = 2'd2
  } laneMode_e;

  // Strobes handed from the control unit to the datapath.
  typedef struct packed {
    laneMode_e mode;
    logic      sat;
    logic      sgn;
    logic      sub;
    logic      load;
  } ctrlStrobe_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  laneSel,
  input  logic        satEn,
  input  logic        signedEn,
  input  logic        subEn,
  output ctrlStrobe_t ctrl,
  output logic        outValid
);

  laneMode_e modeDec;

  always_comb begin
    unique case (laneSel)
      2'd0:    modeDec = LANE8;
      2'd1:    modeDec = LANE16;
      default: modeDec = LANE32;
    endcase
  end

  always_comb begin
    ctrl.mode = modeDec;
    ctrl.sat  = satEn;
    ctrl.sgn  = signedEn;
    ctrl.sub  = subEn;
    ctrl.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 8,
  localparam int unsigned DATA_W   = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [NUM_BYTES-1:0] ovfFlags
);

  localparam int unsigned MSB = BYTE_W - 1;

  logic [NUM_BYTES-1:0] topOvf;   // overflow seen at a byte acting as lane top
  logic [NUM_BYTES-1:0] topUp;    // clamp direction seen at that byte
  logic [NUM_BYTES-1:0] laneOvf;  // overflow of the lane holding each byte
  logic [DATA_W-1:0]    nextRes;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam int unsigned TOP16 = i | 1;
    localparam int unsigned TOP32 = i | 3;

    logic              isStart;
    logic              isTop;
    logic              carryIn;
    logic              carryOut;
    logic [BYTE_W-1:0] aByte;
    logic [BYTE_W-1:0] bByte;
    logic [BYTE_W-1:0] rawByte;
    logic [BYTE_W-1:0] satByte;
    logic              sOvf;
    logic              uOvf;
    logic              laneUp;

    always_comb begin
      unique case (ctrl.mode)
        LANE8:   begin isStart = 1'b1;          isTop = 1'b1;          end
        LANE16:  begin isStart = (i % 2) == 0;  isTop = (i % 2) == 1;  end
        default: begin isStart = (i % 4) == 0;  isTop = (i % 4) == 3;  end
      endcase
    end

    if (i == 0) begin : g_first
      assign carryIn = ctrl.sub;
    end else begin : g_chain
      assign carryIn = isStart ? ctrl.sub : g_byte[i-1].carryOut;
    end

    assign aByte = opA[i*BYTE_W +: BYTE_W];
    assign bByte = ctrl.sub ? ~opB[i*BYTE_W +: BYTE_W] : opB[i*BYTE_W +: BYTE_W];
    assign {carryOut, rawByte} = {1'b0, aByte} + {1'b0, bByte} + {{BYTE_W{1'b0}}, carryIn};

    // Overflow evaluation, meaningful where this byte is a lane top.
    assign sOvf = (aByte[MSB] == bByte[MSB]) && (rawByte[MSB] != aByte[MSB]);
    assign uOvf = carryOut ^ ctrl.sub;
    assign topOvf[i] = ctrl.sgn ? sOvf : uOvf;
    assign topUp[i]  = ctrl.sgn ? ~aByte[MSB] : ~ctrl.sub;

    // Fetch the lane verdict from the lane's top byte.
    always_comb begin
      unique case (ctrl.mode)
        LANE8:   begin laneOvf[i] = topOvf[i];     laneUp = topUp[i];     end
        LANE16:  begin laneOvf[i] = topOvf[TOP16]; laneUp = topUp[TOP16]; end
        default: begin laneOvf[i] = topOvf[TOP32]; laneUp = topUp[TOP32]; end
      endcase
    end

    assign satByte = {(isTop && ctrl.sgn) ? ~laneUp : laneUp, {(BYTE_W-1){laneUp}}};
    assign nextRes[i*BYTE_W +: BYTE_W] = (ctrl.sat && laneOvf[i]) ? satByte : rawByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      ovfFlags <= '0;
    end else if (ctrl.load) begin
      result   <= nextRes;
      ovfFlags <= laneOvf;
    end
  end

endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
  import simd_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 8,
  localparam int unsigned DATA_W   = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           laneSel,
  input  logic                 satEn,
  input  logic                 signedEn,
  input  logic                 subEn,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic                 outValid,
  output logic [DATA_W-1:0]    result,
  output logic [NUM_BYTES-1:0] ovfFlags
);

  ctrlStrobe_t ctrl;

  simd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .laneSel  (laneSel),
    .satEn    (satEn),
    .signedEn (signedEn),
    .subEn    (subEn),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  simd_datapath #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .ovfFlags (ovfFlags)
  );

endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 8,
  localparam int unsigned DATA_W   = BYTE_W * NUM_BYTES
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [1:0]           laneSel,
  input logic                 satEn,
  input logic                 signedEn,
  input logic                 subEn,
  input logic [DATA_W-1:0]    opA,
  input logic [DATA_W-1:0]    opB,
  input logic                 outValid,
  input logic [DATA_W-1:0]    result,
  input logic [NUM_BYTES-1:0] ovfFlags
);

  localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};

  logic [BYTE_W:0] low8Sum;
  assign low8Sum = {1'b0, opA[BYTE_W-1:0]} + {1'b0, opB[BYTE_W-1:0]};

  // R10: one-cycle valid latency
  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R10: idle cycle leaves outputs untouched
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(ovfFlags)));

  // R1: lowest byte lane wraps on its own in byte mode
  p_lane_iso_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel == 2'd0 && !satEn && !subEn)
    |=> result[BYTE_W-1:0] == $past(low8Sum[BYTE_W-1:0]));

  // R9: a 32-bit lane flag covers all its bytes
  p_flag_rep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel[1])
    |=> ($countones(ovfFlags[3:0]) == 0 || $countones(ovfFlags[3:0]) == 4));

  // R8: unsigned saturating add clamps lane 0 to all ones
  p_usat_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel == 2'd0 && satEn && !signedEn && !subEn && low8Sum[BYTE_W])
    |=> (result[BYTE_W-1:0] == {BYTE_W{1'b1}} && ovfFlags[0]));

  // R7: signed max plus a positive value clamps to signed max
  p_ssat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel == 2'd0 && satEn && signedEn && !subEn &&
     opA[BYTE_W-1:0] == SMAX && !opB[BYTE_W-1] && opB[BYTE_W-1:0] != '0)
    |=> (result[BYTE_W-1:0] == SMAX && ovfFlags[0]));

endmodule

bind simd_sat_add simd_sat_add_chk #(
  .BYTE_W    (BYTE_W),
  .NUM_BYTES (NUM_BYTES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .laneSel  (laneSel),
  .satEn    (satEn),
  .signedEn (signedEn),
  .subEn    (subEn),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .result   (result),
  .ovfFlags (ovfFlags)
);

// File: tb/sim_simd_sat_add.sv
module sim_simd_sat_add;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  laneSel = '0;
  logic        satEn = 1'b0;
  logic        signedEn = 1'b0;
  logic        subEn = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;
  logic [7:0]  ovfFlags;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state (held between valid operations)
  logic [63:0] expRes = '0;
  logic [7:0]  expFlg = '0;
  logic        expVld = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_add u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneSel(laneSel),
    .satEn(satEn), .signedEn(signedEn), .subEn(subEn),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .ovfFlags(ovfFlags)
  );

  task automatic model(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] sel, input logic sat,
                       input logic sgn, input logic sub,
                       output logic [63:0] res, output logic [7:0] flg);
    int lb = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
    int w  = 8 * lb;
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    res = '0;
    flg = '0;
    for (int l = 0; l < 8 / lb; l++) begin
      longint ua = longint'((a >> (l * w))) & mask;
      longint ub = longint'((b >> (l * w))) & mask;
      longint r;
      longint clampV;
      longint v;
      bit o;
      if (sgn) begin
        longint sa = (ua >= half) ? ua - (mask + 1) : ua;
        longint sb = (ub >= half) ? ub - (mask + 1) : ub;
        r = sub ? sa - sb : sa + sb;
        o = (r > half - 1) || (r < -half);
        clampV = (r > half - 1) ? half - 1 : -half;
      end else begin
        r = sub ? ua - ub : ua + ub;
        o = (r < 0) || (r > mask);
        clampV = (r < 0) ? 0 : mask;
      end
      v = (sat && o) ? clampV : r;
      res = res | (64'(v & mask) << (l * w));
      for (int k = 0; k < lb; k++) flg[l * lb + k] = o;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (outValid !== expVld || result !== expRes || ovfFlags !== expFlg) begin
      errors++;
      $display("FAIL %s: got vld=%0b res=%h flg=%b, expected vld=%0b res=%h flg=%b",
               tag, outValid, result, ovfFlags, expVld, expRes, expFlg);
    end
  endtask

  // Drive one cycle at the falling edge, check after the next rising edge.
  task automatic step(input logic vld, input logic [1:0] sel, input logic sat,
                      input logic sgn, input logic sub,
                      input logic [63:0] a, input logic [63:0] b,
                      input string tag);
    logic [63:0] r;
    logic [7:0]  f;
    inValid = vld; laneSel = sel; satEn = sat; signedEn = sgn; subEn = sub;
    opA = a; opB = b;
    if (vld) begin
      model(a, b, sel, sat, sgn, sub, r, f);
      expRes = r;
      expFlg = f;
    end
    expVld = vld;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    compare("R11 reset");
    rstN = 1'b1;

    // R1/R2: byte lane 0 carry must not reach byte 1
    step(1, 2'd0, 0, 0, 0, 64'h0000_0000_0000_10FF, 64'h0000_0000_0000_0001, "R1 byte seam");
    // R1: 16-bit seam
    step(1, 2'd1, 0, 0, 0, 64'h0001_FFFF_00FF_FFFF, 64'h0000_0001_0001_0001, "R1 half seam");
    // R1: 32-bit seam, code 2 and code 3
    step(1, 2'd2, 0, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R1 word seam");
    step(1, 2'd3, 0, 0, 0, 64'h1234_5678_FFFF_FFFF, 64'h0000_0001_0000_0002, "R1 code3");
    // R3/R2: wrap subtraction with borrow at seams
    step(1, 2'd0, 0, 0, 1, 64'h0500_0000_0000_0100, 64'h0600_0000_0000_0001, "R3 sub wrap");
    step(1, 2'd1, 0, 1, 1, 64'h8000_0000_7FFF_0000, 64'h0001_0001_FFFF_0001, "R2 R5 signed sub wrap");
    // R4/R7: signed add overflow up and down
    step(1, 2'd0, 1, 1, 0, 64'h8080_7F7F_4040_0101, 64'h80FF_017F_4040_FEFF, "R4 R7 signed add sat");
    step(1, 2'd2, 1, 1, 0, 64'h8000_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0001, "R7 signed 32 sat");
    // R5/R7: signed sub overflow
    step(1, 2'd1, 1, 1, 1, 64'h8000_7FFF_0005_8000, 64'h0001_FFFF_0007_8000, "R5 R7 signed sub sat");
    // R6/R8: unsigned sat add and sub
    step(1, 2'd0, 1, 0, 0, 64'hFF80_0102_FFFF_8000, 64'h0180_0304_0000_8001, "R6 R8 unsigned add sat");
    step(1, 2'd1, 1, 0, 1, 64'h0000_0005_1234_FFFF, 64'h0001_0006_1234_0000, "R6 R8 unsigned sub sat");
    // R9: replicated flags in 16- and 32-bit modes
    step(1, 2'd1, 0, 0, 0, 64'hFFFF_0000_FFFF_0001, 64'h0001_0000_0001_0001, "R9 flags half");
    step(1, 2'd2, 0, 1, 0, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, "R9 flags word");
    // R10: idle cycles hold outputs and drop valid
    step(0, 2'd0, 1, 1, 1, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1111_2222_3333_4444, "R10 hold");
    step(0, 2'd2, 0, 0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R10 hold2");

    // Mixed random sweep over all control combinations
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      logic [4:0]  cfg = 5'($urandom);
      if (n % 4 == 0) rb = ~ra;
      step(1'(n % 7 != 6), cfg[1:0], cfg[2], cfg[3], cfg[4], ra, rb, "R2 R6 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: got running, expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule